// File: doc/BRIEF.md
# Isolated-Bit Equalizer Trainer

This block tunes a receiver's linear equalizer code from timing votes alone. The clock-recovery loop occasionally captures a burst of data samples together with the edge samples taken between them. The trainer scans each aligned pair of words for a lone bit, meaning a single 1 after at least three 0s and followed by a 0, or the inverse case. It then reads the edge sample on each side of that bit. A late first transition together with an early second one means the pulse has spread, so the equalizer is too weak. The opposite pairing means it is too strong.

Votes are collected over a programmable number of qualifying bits. At the end of that window the code moves one step, but only when the votes in one direction outnumber the other by at least a programmable margin. The code is clamped at both ends of its range. Votes are taken only while the clock-recovery loop reports lock. The last four samples of the previous word are kept, so a lone bit that straddles two words of the same burst is still found.

Top module: `eq_adapt`

## Requirements
- R1: Bit 0 of `data_word` is the earliest sample. `edge_word[i]` is the edge sample taken just before data bit i, and the previous word's last four bits are logically older than bit 0. A qualifying bit x at position p needs positions p-3, p-2, p-1 and p+1 all equal to the inverse of x; no other pattern casts a vote.
- R2: When the edge sample before the qualifying bit equals x (late) and the edge sample after it also equals x (early), an up vote is cast. A window closed by up votes alone raises `eq_code` by exactly one on the clock edge that accepts the word.
- R3: When both of those edge samples differ from x (first early, second late), a down vote is cast. A window of down votes lowers `eq_code` by one.
- R4: A qualifying bit whose two edge samples agree in direction (both early or both late) counts toward the window but casts no vote. A word with no qualifying bit leaves `eq_code` unchanged.
- R5: A window closes on the accepted word that brings the number of qualifying bits to at least `win_len` (set to 1 or more). Closing the window clears all counts, and any surplus bits in that word are dropped.
- R6: When a window closes, the code steps up only if up votes exceed down votes by at least `thresh`, and steps down only if down votes exceed up votes by at least `thresh`. Otherwise it holds.
- R7: `eq_code` saturates at 0 and at 2^EQW-1 and never wraps.
- R8: A word accepted while `cdr_locked` is low casts no vote, leaves `eq_code` unchanged and clears the partial window.
- R9: With `burst_first` low, a qualifying bit whose pattern starts in the previous word's last four bits is detected. With `burst_first` high, only patterns lying wholly inside the current word count.
- R10: Every qualifying bit in a word is counted, so one word can hold several of them.
- R11: Reset sets `eq_code` to EQ_INIT (8 by default). The code changes only on a clock edge where `word_vld` is high, and by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_vld | input | 1 | Data and edge words valid this cycle |
| burst_first | input | 1 | First word of a capture burst; sample history is ignored |
| cdr_locked | input | 1 | Clock-recovery lock indication |
| data_word | input | W | Data samples, bit 0 earliest |
| edge_word | input | W | Edge samples, bit i taken before data bit i |
| win_len | input | WINW | Qualifying bits per decision window |
| thresh | input | WINW | Required vote margin for a step |
| eq_code | output | EQW | Equalizer setting |

## Verification
The bench targets a lone bit that straddles two words. A design that drops the history misses the step, and a design that ignores `burst_first` invents a step from stale samples. It drives a word holding two lone bits, which a design counting one per word would fail to close. It drives a near-balanced window that must not step, which a design taking the sign of the vote difference would step anyway. Runs to both ends of the code range show up any wrap. A loss of lock in the middle of a window must restart the count, and a design that keeps the stale votes steps one word too early.

// File: rtl/eq_adapt.sv
module eq_adapt #(
  parameter int W       = 16,
  parameter int EQW     = 4,
  parameter int EQ_INIT = 8,
  parameter int WINW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_vld,
  input  logic            burst_first,
  input  logic            cdr_locked,
  input  logic [W-1:0]    data_word,
  input  logic [W-1:0]    edge_word,
  input  logic [WINW-1:0] win_len,
  input  logic [WINW-1:0] thresh,
  output logic [EQW-1:0]  eq_code
);
  localparam int CW = $clog2(W + 1);
  localparam int SW = WINW + CW;
  localparam logic [EQW-1:0] EQ_MAX = {EQW{1'b1}};

  logic [3:0]    d_hist, e_hist;
  logic [SW-1:0] seen, ups, dns;
  logic [W-1:0]  hit_v, up_v, dn_v;
  logic [SW-1:0] n_hit, n_up, n_dn;

  wire [W+3:0] cd = {data_word, d_hist};
  wire [W+3:0] ce = {edge_word, e_hist};

  for (genvar g = 0; g < W; g++) begin : g_scan
    localparam int K = g + 4;
    wire x     = cd[K-1];
    wire iso   = (cd[K-4] != x) && (cd[K-3] != x) && (cd[K-2] != x) && (cd[K] != x);
    wire ok    = (g >= 4) || !burst_first;
    wire late  = (ce[K-1] == x);
    wire early = (ce[K] == x);
    assign hit_v[g] = iso && ok;
    assign up_v[g]  = hit_v[g] && late && early;
    assign dn_v[g]  = hit_v[g] && !late && !early;
  end

  always_comb begin
    n_hit = '0;
    n_up  = '0;
    n_dn  = '0;
    for (int i = 0; i < W; i++) begin
      n_hit = n_hit + SW'(hit_v[i]);
      n_up  = n_up + SW'(up_v[i]);
      n_dn  = n_dn + SW'(dn_v[i]);
    end
  end

  wire [SW-1:0] tot    = seen + n_hit;
  wire [SW-1:0] up_tot = ups + n_up;
  wire [SW-1:0] dn_tot = dns + n_dn;
  wire [SW-1:0] thr_x  = SW'(thresh);
  wire          take   = word_vld && cdr_locked;
  wire          close  = take && (n_hit != '0) && (tot >= SW'(win_len));
  wire          go_up  = (up_tot > dn_tot) && ((up_tot - dn_tot) >= thr_x);
  wire          go_dn  = (dn_tot > up_tot) && ((dn_tot - up_tot) >= thr_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_hist  <= '0;
      e_hist  <= '0;
      seen    <= '0;
      ups     <= '0;
      dns     <= '0;
      eq_code <= EQW'(EQ_INIT);
    end else if (word_vld) begin
      d_hist <= data_word[W-1:W-4];
      e_hist <= edge_word[W-1:W-4];
      if (!cdr_locked || close) begin
        seen <= '0;
        ups  <= '0;
        dns  <= '0;
      end else begin
        seen <= tot;
        ups  <= up_tot;
        dns  <= dn_tot;
      end
      if (close && go_up && eq_code != EQ_MAX) eq_code <= eq_code + 1'b1;
      else if (close && go_dn && eq_code != '0) eq_code <= eq_code - 1'b1;
    end
  end

  a_r11_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_code != $past(eq_code)) |->
      ($past(word_vld) && (eq_code == $past(eq_code) + 1'b1 || eq_code == $past(eq_code) - 1'b1)));

  a_r8_hold_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !cdr_locked |=> $stable(eq_code));

  a_r7_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_code == EQ_MAX) |=> (eq_code != '0));

  a_r7_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_code == '0) |=> (eq_code != EQ_MAX));

  a_r5_votes_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (ups + dns) <= seen);
endmodule

// File: tb/eq_adapt_bench.sv
module eq_adapt_bench;
  localparam int PERIOD = 10;
  localparam int W = 16;

  logic clk = 0, rst_n = 0, word_vld = 0, burst_first = 0, cdr_locked = 1;
  logic [W-1:0] data_word = '0, edge_word = '0;
  logic [7:0] win_len = 8'd1, thresh = 8'd1;
  logic [3:0] eq_code;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  eq_adapt u_eq_adapt (.clk, .rst_n, .word_vld, .burst_first, .cdr_locked,
    .data_word, .edge_word, .win_len, .thresh, .eq_code);

  // {burst_first, data, edges, expected code after the word}
  localparam logic [36:0] VEC [10] = '{
    {1'b1, 16'h0020, 16'h0060, 4'd9},   // R2 lone 1, up
    {1'b1, 16'hFFDF, 16'hFF9F, 4'd10},  // R2 lone 0, up
    {1'b1, 16'h0020, 16'h0000, 4'd9},   // R3 lone 1, down
    {1'b1, 16'h0020, 16'h0020, 4'd9},   // R4 mixed
    {1'b1, 16'hFFDF, 16'hFFFF, 4'd8},   // R3 lone 0, down
    {1'b1, 16'h0000, 16'h0000, 4'd8},   // R4 no pattern
    {1'b1, 16'h8000, 16'h8000, 4'd8},   // R1 lone bit at last position, no trailing bit yet
    {1'b0, 16'h0000, 16'h0001, 4'd9},   // R9 spans words
    {1'b1, 16'h8000, 16'h8000, 4'd9},
    {1'b1, 16'h0000, 16'h0001, 4'd9}    // R9 history ignored at burst start
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(logic bf, logic [W-1:0] d, logic [W-1:0] e, logic lk);
    @(negedge clk);
    burst_first = bf; data_word = d; edge_word = e; cdr_locked = lk; word_vld = 1;
    @(negedge clk);
    word_vld = 0; cdr_locked = 1;
  endtask

  task automatic up_w();   send(1, 16'h0020, 16'h0060, 1); endtask
  task automatic down_w(); send(1, 16'h0020, 16'h0000, 1); endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk) rst_n = 1;
    chk("R11 reset value", eq_code, 8);

    foreach (VEC[i]) begin
      send(VEC[i][36], VEC[i][35:20], VEC[i][19:4], 1);
      chk($sformatf("R1/R2/R3/R4/R9 vector %0d", i), eq_code, VEC[i][3:0]);
    end

    @(negedge clk);
    data_word = 16'h0020; edge_word = 16'h0060; burst_first = 1; word_vld = 0;
    @(negedge clk);
    chk("R11 idle word ignored", eq_code, 9);

    send(1, 16'h0020, 16'h0060, 0);
    chk("R8 unlocked word ignored", eq_code, 9);

    for (int i = 0; i < 20; i++) up_w();
    chk("R7 top saturation", eq_code, 15);
    for (int i = 0; i < 20; i++) down_w();
    chk("R7 bottom saturation", eq_code, 0);
    for (int i = 0; i < 8; i++) up_w();
    chk("R2 climb back", eq_code, 8);

    win_len = 8'd3; thresh = 8'd1;
    up_w(); up_w();
    chk("R5 window still open", eq_code, 8);
    up_w();
    chk("R5 window closes", eq_code, 9);

    thresh = 8'd2;
    up_w(); up_w(); down_w();
    chk("R6 margin too small", eq_code, 9);
    up_w(); up_w(); up_w();
    chk("R6 margin met", eq_code, 10);

    win_len = 8'd2; thresh = 8'd2;
    send(1, 16'h0820, 16'h1860, 1);
    chk("R10 two lone bits in one word", eq_code, 11);

    thresh = 8'd1;
    up_w();
    send(1, 16'h0020, 16'h0060, 0);
    up_w();
    chk("R8 unlock restarts window", eq_code, 11);
    up_w();
    chk("R8 window after relock", eq_code, 12);

    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    chk("R11 reset mid-run", eq_code, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule